// File: doc/BRIEF.md
# Three-Level Flying-Capacitor Gate Pattern Generator

This block drives one switching cell of a three-level flying-capacitor converter. It produces four gate enables. The outer pair is S1 with its complement S4. The inner pair is S2 with its complement S3. A free-running phase counter sets the switching period. From that counter the block derives two triangular carriers that are half a period apart. Both carriers are compared against the same duty word, so the outer and inner pairs get the same on-time. Because the two pairs are shifted by half a period, the switching node toggles at twice the carrier rate.

Each complementary pair has its own programmable dead time. Dead time is inserted by holding back every rising edge by that many clock cycles. Falling edges are never delayed, so within a pair the two gates always share an all-off gap.

The period, duty and dead-time inputs are copied into working registers only at a period boundary, or at any time while the block is disabled. A change in the middle of a cycle therefore never produces a runt pulse. A duty of zero keeps S1 and S2 off for the whole period. A duty at or above the period value keeps them fully on.

Top module: `fc3l_pwm`

## Requirements
- R1: While `rst` is high, or from the first clock edge after `en` goes low, all four gate outputs are low.
- R2: `gate_s1_o` and `gate_s4_o` are never high in the same cycle, and `gate_s2_o` and `gate_s3_o` are never high in the same cycle.
- R3: The half-period value P equals `period_i`, raised to 2 when `period_i` is below 2. Every gate pattern repeats every 2·P clock cycles, and successive rising edges of `gate_s1_o` are 2·P cycles apart.
- R4: With duty D where 0 < D < P, `gate_s1_o` is high for 2·D − `dt_outer_i` cycles per period and `gate_s2_o` is high for 2·D − `dt_inner_i` cycles per period.
- R5: With 0 < D < P, `gate_s4_o` is high for 2·(P−D) − `dt_outer_i` cycles per period and `gate_s3_o` is high for 2·(P−D) − `dt_inner_i` cycles per period.
- R6: With equal dead times on both pairs, a rising edge of `gate_s2_o` follows each rising edge of `gate_s1_o` by exactly P cycles.
- R7: Within each pair, both gates are low for exactly 2·dt cycles per period, where dt is that pair's dead time. A gate is high only if the raw comparison for that gate was high in the previous cycle.
- R8: A duty of D ≥ P holds S1 and S2 high and S3 and S4 low for the whole period. A duty of D = 0 holds S1 and S2 low and S3 and S4 high.
- R9: With D = P/2 and zero dead time, each of the four gates is high for exactly P cycles per period.
- R10: With D > P/2, S1 and S2 are both high in some cycles of every period. With D < P/2, they are never high together.
- R11: A new `duty_i` value has no effect on the pulse in progress. The current `gate_s2_o` pulse keeps the old width, and the new width first appears in the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low forces all gates off and restarts the phase |
| period_i | input | CNT_W | Half-period P in clock cycles |
| duty_i | input | CNT_W | Duty value D; the on-time of S1 and S2 is 2·D cycles before dead time |
| dt_outer_i | input | DT_W | Dead time for the S1/S4 pair, in cycles |
| dt_inner_i | input | DT_W | Dead time for the S2/S3 pair, in cycles |
| gate_s1_o | output | 1 | Outer upper switch gate |
| gate_s2_o | output | 1 | Inner upper switch gate |
| gate_s3_o | output | 1 | Inner lower switch gate, complement of S2 |
| gate_s4_o | output | 1 | Outer lower switch gate, complement of S1 |

## Verification
Some internal faults show up within one period of 2·P cycles:
- a phase counter that wraps at the wrong count changes the spacing between rising edges;
- a wrong carrier offset changes the S1-to-S2 delay away from P;
- an off-by-one compare changes the per-period on-counts by two.

A fault in a dead-time counter appears at the next edge of the affected pair, as an all-off gap of the wrong length or as overlap inside the pair. A fault in the working-register load appears only when an input changes mid-period: the pulse already in progress takes on the new width one period early.

// File: rtl/fc3l_pkg.sv
package fc3l_pkg;

    // Gate indices; the order fixes which raw signal and dead time feed each gate.
    localparam int GATE_S1 = 0;
    localparam int GATE_S2 = 1;
    localparam int GATE_S3 = 2;
    localparam int GATE_S4 = 3;
    localparam int NUM_GATES = 4;

    // Smallest half-period that still gives a proper triangle.
    localparam int MIN_HALF_PERIOD = 2;

endpackage

// File: rtl/fc3l_carrier.sv
module fc3l_carrier
    import fc3l_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [DT_W-1:0]  dt_outer_i,
    input  logic [DT_W-1:0]  dt_inner_i,
    output logic             raw_a_o,
    output logic             raw_b_o,
    output logic [DT_W-1:0]  dt_outer_o,
    output logic [DT_W-1:0]  dt_inner_o
);

    localparam int PH_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(MIN_HALF_PERIOD);

    typedef struct packed {
        logic [PH_W-1:0]  ph;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
        logic [DT_W-1:0]  dto;
        logic [DT_W-1:0]  dti;
    } car_st_t;

    localparam car_st_t RST_ST = '{ph: '0, per: MIN_PER, duty: '0, dto: '0, dti: '0};

    car_st_t st_d, st_q;

    logic [PH_W-1:0]  per_ext_d;
    logic [PH_W-1:0]  last_d;
    logic [PH_W-1:0]  tri_a_d;
    logic [PH_W-1:0]  tri_b_d;
    logic [CNT_W-1:0] car_a_d;
    logic [CNT_W-1:0] car_b_d;
    logic             load_d;

    always_comb begin
        st_d      = st_q;
        per_ext_d = {1'b0, st_q.per};
        last_d    = (per_ext_d << 1) - PH_W'(1);
        load_d    = !en || (st_q.ph >= last_d);

        if (load_d) begin
            st_d.ph   = '0;
            st_d.per  = (period_i < MIN_PER) ? MIN_PER : period_i;
            st_d.duty = duty_i;
            st_d.dto  = dt_outer_i;
            st_d.dti  = dt_inner_i;
        end else begin
            st_d.ph = st_q.ph + PH_W'(1);
        end

        // Carrier A rises over the first half and falls over the second.
        // Carrier B is the same shape shifted by half a period.
        if (st_q.ph < per_ext_d) begin
            tri_a_d = st_q.ph;
            tri_b_d = per_ext_d - PH_W'(1) - st_q.ph;
        end else begin
            tri_a_d = last_d - st_q.ph;
            tri_b_d = st_q.ph - per_ext_d;
        end
        car_a_d = tri_a_d[CNT_W-1:0];
        car_b_d = tri_b_d[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= RST_ST;
        else     st_q <= st_d;
    end

    assign raw_a_o    = en && (car_a_d < st_q.duty);
    assign raw_b_o    = en && (car_b_d < st_q.duty);
    assign dt_outer_o = st_q.dto;
    assign dt_inner_o = st_q.dti;

    // R3: the phase stays inside one period of 2*P.
    p_phase_in_period_r3: assert property (@(posedge clk) disable iff (rst)
        st_q.ph < ({1'b0, st_q.per} << 1));

    // R11: working duty and period change only when a new period begins.
    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (st_q.ph != '0) |-> ($stable(st_q.duty) && $stable(st_q.per)));

    // R8: a duty at or above P keeps both raw signals on.
    p_full_on_r8: assert property (@(posedge clk) disable iff (rst)
        (en && st_q.duty >= st_q.per) |-> (raw_a_o && raw_b_o));

endmodule

// File: rtl/fc3l_deadtime.sv
module fc3l_deadtime #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            kill_i,
    input  logic            raw_i,
    input  logic [DT_W-1:0] dt_i,
    output logic            gate_o
);

    localparam logic [DT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [DT_W-1:0] cnt;
        logic            gate;
    } dt_st_t;

    dt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (kill_i || !raw_i) begin
            // Falling edges pass straight through and restart the delay count.
            st_d.cnt  = '0;
            st_d.gate = 1'b0;
        end else begin
            st_d.gate = (st_q.cnt >= dt_i);
            st_d.cnt  = (st_q.cnt == CNT_MAX) ? st_q.cnt : st_q.cnt + DT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign gate_o = st_q.gate;

    // R7: a gate is on only if its raw request was on one cycle before.
    p_gate_needs_raw_r7: assert property (@(posedge clk) disable iff (rst)
        gate_o |-> $past(raw_i && !kill_i));

endmodule

// File: rtl/fc3l_pwm.sv
module fc3l_pwm
    import fc3l_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [DT_W-1:0]  dt_outer_i,
    input  logic [DT_W-1:0]  dt_inner_i,
    output logic             gate_s1_o,
    output logic             gate_s2_o,
    output logic             gate_s3_o,
    output logic             gate_s4_o
);

    logic            raw_a;
    logic            raw_b;
    logic [DT_W-1:0] dto_w;
    logic [DT_W-1:0] dti_w;

    logic [NUM_GATES-1:0] raw_sel;
    logic [DT_W-1:0]      dt_sel [NUM_GATES];
    logic [NUM_GATES-1:0] gate_w;

    fc3l_carrier #(
        .CNT_W (CNT_W),
        .DT_W  (DT_W)
    ) u_carrier (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .period_i   (period_i),
        .duty_i     (duty_i),
        .dt_outer_i (dt_outer_i),
        .dt_inner_i (dt_inner_i),
        .raw_a_o    (raw_a),
        .raw_b_o    (raw_b),
        .dt_outer_o (dto_w),
        .dt_inner_o (dti_w)
    );

    // The outer pair follows carrier A and the inner pair follows carrier B.
    always_comb begin
        raw_sel[GATE_S1] = raw_a;
        raw_sel[GATE_S4] = !raw_a;
        raw_sel[GATE_S2] = raw_b;
        raw_sel[GATE_S3] = !raw_b;
        dt_sel[GATE_S1]  = dto_w;
        dt_sel[GATE_S4]  = dto_w;
        dt_sel[GATE_S2]  = dti_w;
        dt_sel[GATE_S3]  = dti_w;
    end

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_dt
        fc3l_deadtime #(
            .DT_W (DT_W)
        ) u_dt (
            .clk    (clk),
            .rst    (rst),
            .kill_i (!en),
            .raw_i  (raw_sel[g]),
            .dt_i   (dt_sel[g]),
            .gate_o (gate_w[g])
        );
    end

    assign gate_s1_o = gate_w[GATE_S1];
    assign gate_s2_o = gate_w[GATE_S2];
    assign gate_s3_o = gate_w[GATE_S3];
    assign gate_s4_o = gate_w[GATE_S4];

    // R2: no overlap in either complementary pair.
    p_outer_no_overlap_r2: assert property (@(posedge clk) disable iff (rst)
        !(gate_s1_o && gate_s4_o));
    p_inner_no_overlap_r2: assert property (@(posedge clk) disable iff (rst)
        !(gate_s2_o && gate_s3_o));

    // R1: disabling turns every gate off at the next edge.
    p_off_when_disabled_r1: assert property (@(posedge clk) disable iff (rst)
        !en |=> !(gate_s1_o || gate_s2_o || gate_s3_o || gate_s4_o));

endmodule

// File: tb/tb_fc3l_pwm.sv
module tb_fc3l_pwm;

    localparam int CNT_W = 16;
    localparam int DT_W  = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b0;
    logic [CNT_W-1:0] period_i = '0;
    logic [CNT_W-1:0] duty_i = '0;
    logic [DT_W-1:0]  dt_outer_i = '0;
    logic [DT_W-1:0]  dt_inner_i = '0;
    logic             s1, s2, s3, s4;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fc3l_pwm #(.CNT_W(CNT_W), .DT_W(DT_W)) dut (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .period_i   (period_i),
        .duty_i     (duty_i),
        .dt_outer_i (dt_outer_i),
        .dt_inner_i (dt_inner_i),
        .gate_s1_o  (s1),
        .gate_s2_o  (s2),
        .gate_s3_o  (s3),
        .gate_s4_o  (s4)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Load a configuration while disabled, then run until steady.
    task automatic apply(input int p, input int d, input int dto, input int dti);
        int pe;
        pe = (p < 2) ? 2 : p;
        @(negedge clk);
        en = 1'b0;
        period_i = CNT_W'(p);
        duty_i = CNT_W'(d);
        dt_outer_i = DT_W'(dto);
        dt_inner_i = DT_W'(dti);
        repeat (2) @(negedge clk);
        en = 1'b1;
        repeat (6 * pe + 10) @(negedge clk);
    endtask

    // Count gate activity over len consecutive cycles.
    task automatic measure(input int len, output int n1, output int n2, output int n3,
                           output int n4, output int lowa, output int lowb,
                           output int ov12, output int ovp);
        n1 = 0; n2 = 0; n3 = 0; n4 = 0; lowa = 0; lowb = 0; ov12 = 0; ovp = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            n1 += int'(s1); n2 += int'(s2); n3 += int'(s3); n4 += int'(s4);
            lowa += int'(!s1 && !s4);
            lowb += int'(!s2 && !s3);
            ov12 += int'(s1 && s2);
            ovp  += int'((s1 && s4) || (s2 && s3));
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; en = 1'b1;
        period_i = 16'd20; duty_i = 16'd6; dt_outer_i = 8'd1; dt_inner_i = 8'd1;
        repeat (5) @(negedge clk);
        chk("R1 gates low in reset", int'({s1, s2, s3, s4}), 0);
        en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 gates low while disabled", int'({s1, s2, s3, s4}), 0);
    endtask

    task automatic t_mid();
        int n1, n2, n3, n4, la, lb, o12, op;
        apply(20, 6, 3, 2);
        measure(40, n1, n2, n3, n4, la, lb, o12, op);
        chk("R4 S1 on-count", n1, 9);
        chk("R4 S2 on-count", n2, 10);
        chk("R5 S4 on-count", n4, 25);
        chk("R5 S3 on-count", n3, 26);
        chk("R7 outer all-off gap", la, 6);
        chk("R7 inner all-off gap", lb, 4);
        chk("R2 pair overlap", op, 0);
        chk("R10 low duty S1/S2 overlap", o12, 0);
    endtask

    task automatic t_half();
        int n1, n2, n3, n4, la, lb, o12, op;
        apply(20, 10, 0, 0);
        measure(40, n1, n2, n3, n4, la, lb, o12, op);
        chk("R9 S1 half", n1, 20);
        chk("R9 S2 half", n2, 20);
        chk("R9 S3 half", n3, 20);
        chk("R9 S4 half", n4, 20);
    endtask

    // Rising-edge spacing: S1 to S2 and S1 to the next S1.
    task automatic t_phase(input int p, input int d, input int dt);
        int pe, k, k2;
        logic p1, p2;
        pe = (p < 2) ? 2 : p;
        apply(p, d, dt, dt);
        p1 = s1;
        forever begin
            @(negedge clk);
            if (s1 && !p1) break;
            p1 = s1;
        end
        k = 0; k2 = -1; p1 = s1; p2 = s2;
        forever begin
            @(negedge clk);
            k++;
            if (s2 && !p2 && k2 < 0) k2 = k;
            if (s1 && !p1) break;
            p1 = s1; p2 = s2;
            if (k > 4 * pe) break;
        end
        chk("R6 S1 to S2 rise delay", k2, pe);
        chk("R3 S1 rise spacing", k, 2 * pe);
    endtask

    task automatic t_high();
        int n1, n2, n3, n4, la, lb, o12, op;
        apply(20, 15, 2, 2);
        measure(40, n1, n2, n3, n4, la, lb, o12, op);
        chk("R4 S1 on-count high duty", n1, 28);
        chk("R5 S3 on-count high duty", n3, 8);
        chk("R10 high duty S1/S2 overlap present", int'(o12 > 0), 1);
        chk("R2 pair overlap high duty", op, 0);
    endtask

    task automatic t_clamp();
        int n1, n2, n3, n4, la, lb, o12, op;
        apply(20, 25, 3, 3);
        measure(40, n1, n2, n3, n4, la, lb, o12, op);
        chk("R8 full duty S1", n1, 40);
        chk("R8 full duty S2", n2, 40);
        chk("R8 full duty S3+S4", n3 + n4, 0);
        apply(20, 0, 3, 3);
        measure(40, n1, n2, n3, n4, la, lb, o12, op);
        chk("R8 zero duty S1+S2", n1 + n2, 0);
        chk("R8 zero duty S4", n4, 40);
        chk("R8 zero duty S3", n3, 40);
    endtask

    task automatic t_min_period();
        int n1, n2, n3, n4, la, lb, o12, op;
        apply(1, 1, 0, 0);
        measure(4, n1, n2, n3, n4, la, lb, o12, op);
        chk("R3 clamped period S1 on-count", n1, 2);
        chk("R3 clamped period S2 on-count", n2, 2);
    endtask

    task automatic t_latch();
        int w;
        logic p2;
        apply(20, 5, 0, 0);
        p2 = s2;
        forever begin
            @(negedge clk);
            if (s2 && !p2) break;
            p2 = s2;
        end
        duty_i = 16'd8;
        w = 1;
        forever begin
            @(negedge clk);
            if (!s2) break;
            w++;
        end
        chk("R11 pulse in progress keeps old width", w, 10);
        forever begin
            @(negedge clk);
            if (s2) break;
        end
        w = 1;
        forever begin
            @(negedge clk);
            if (!s2) break;
            w++;
        end
        chk("R11 next pulse uses new width", w, 16);
    endtask

    task automatic t_disable();
        apply(20, 15, 1, 1);
        repeat (7) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R1 gates low after disable", int'({s1, s2, s3, s4}), 0);
        repeat (5) @(negedge clk);
        chk("R1 gates stay low while disabled", int'({s1, s2, s3, s4}), 0);
    endtask

    initial begin
        t_reset();
        t_mid();
        t_half();
        t_phase(20, 6, 2);
        t_phase(1, 1, 0);
        t_high();
        t_clamp();
        t_min_period();
        t_latch();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule